// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupts

This block sits between the digital result of an analog comparator and the rest of the system. It gates the raw result with the comparator enable, so a disabled comparator always reads as zero. The gated value leaves the block twice. One copy passes straight through with no clock, for wakeup and reset decisions that must work while the system clock is stopped. The other copy goes through a flip-flop synchronizer and becomes the clocked level that software and the interrupt logic see.

A two-state level tracker (states `LVL_LOW` and `LVL_HIGH`) follows the synchronized value. Its transition `LVL_LOW -> LVL_HIGH` emits a one-cycle rise pulse, and its transition `LVL_HIGH -> LVL_LOW` emits a one-cycle fall pulse. Staying in the same state emits nothing. Each pulse sets its own sticky flag, whatever the enables are. Software clears a flag by writing 1 to it. A small register port carries the per-edge interrupt enables, the flag reads and the flag clears. The two flags, masked by their enables, a source enable and a global enable, make one level interrupt request.

Top module: `cmp_irq_cond`

## Requirements
- R1: `cmp_async_o` equals `cmp_raw_i AND cmp_en_i` combinationally, with no clock involved.
- R2: `cmp_sync_o` equals the gated value (`cmp_raw_i AND cmp_en_i`) sampled two clock edges earlier.
- R3: While `cmp_en_i` is 0, both outputs read 0. Turning the comparator off while the synchronized output is high is a normal high-to-low change and sets the fall flag.
- R4: A 0-to-1 change of `cmp_sync_o` sets the rise flag (status bit 1) on the next edge, whatever the enable bits are.
- R5: A 1-to-0 change of `cmp_sync_o` sets the fall flag (status bit 2) on the next edge, whatever the enable bits are.
- R6: A set flag stays set until a write to address 1 carries a 1 in that flag's bit position. Writing 0 to the bit leaves the flag unchanged.
- R7: When a clear and a new edge of the same kind fall in the same cycle, the flag stays set.
- R8: `irq_o` = ((rise flag AND rise enable) OR (fall flag AND fall enable)) AND `src_ie_i` AND `gie_i`. It is a level, not a pulse.
- R9: Address 0 holds the rise enable in bit 0 and the fall enable in bit 1. It is written with `bus_wr_i` and reads back on `bus_rdata_o`, with bit 2 reading 0.
- R10: Address 1 reads the synchronized level in bit 0, the rise flag in bit 1 and the fall flag in bit 2.
- R11: A synchronous reset clears the synchronizer, the flags and the enables to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_raw_i | input | 1 | Raw comparator result (1 when the positive input is above the negative input) |
| cmp_en_i | input | 1 | Comparator enable |
| src_ie_i | input | 1 | Comparator enabled as an interrupt source |
| gie_i | input | 1 | Global interrupt enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register address: 0 = enables, 1 = status |
| bus_wdata_i | input | 3 | Write data |
| bus_rdata_o | output | 3 | Read data for `bus_addr_i`, combinational |
| cmp_async_o | output | 1 | Gated raw output, not clocked |
| cmp_sync_o | output | 1 | Synchronized comparator output |
| irq_o | output | 1 | Interrupt request level |

## Verification
The assertions assume that `cmp_raw_i` and `cmp_en_i` change at most once per clock period and are steady at the sampling edge. They also assume that clears reach the flags only through bus writes to address 1. The bench meets this by changing every input at the falling edge. It holds the raw input steady for random runs of one to four cycles, which gives both isolated one-cycle pulses and longer levels. Bus writes are mixed in at random, and directed cases cover a disable while the output is high and a clear that lands in the same cycle as an edge.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    localparam int REG_W = 3;

    // Register map (addresses)
    localparam logic ADDR_IE   = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Bit positions shared by bus writes and reads
    localparam int B_LVL  = 0;  // status: synchronized level
    localparam int B_RISE = 1;  // status: rise flag
    localparam int B_FALL = 2;  // status: fall flag
    localparam int IE_RISE = 0; // enables: rise
    localparam int IE_FALL = 1; // enables: fall

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

endpackage

// File: rtl/cmp_sync_chain.sv
module cmp_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stage_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[LAST];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/cmp_edge_fsm.sv
module cmp_edge_fsm
    import cmp_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_i,
    output edge_pair_t edge_o
);
    lvl_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LVL_LOW;
        else     state_q <= state_d;
    end

    // Next state and edge outputs
    always_comb begin
        state_d     = state_q;
        edge_o.rise = 1'b0;
        edge_o.fall = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (lvl_i) begin
                    state_d     = LVL_HIGH;
                    edge_o.rise = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!lvl_i) begin
                    state_d     = LVL_LOW;
                    edge_o.fall = 1'b1;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end

    // R4/R5: a single edge kind per cycle
    assert_one_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({edge_o.rise, edge_o.fall}));

    // R3/R5: a high level that drops is reported as a fall in that same cycle
    assert_drop_is_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == LVL_HIGH && !lvl_i) |-> edge_o.fall);
endmodule

// File: rtl/cmp_flag_bank.sv
module cmp_flag_bank
    import cmp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  edge_pair_t       edge_i,
    input  logic             lvl_i,
    input  logic             src_ie_i,
    input  logic             gie_i,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    output logic             irq_o
);
    logic rise_flag_q, fall_flag_q;
    logic rise_ie_q, fall_ie_q;
    logic clr_rise, clr_fall, wr_ie;

    assign wr_ie    = bus_wr_i && (bus_addr_i == ADDR_IE);
    assign clr_rise = bus_wr_i && (bus_addr_i == ADDR_STAT) && bus_wdata_i[B_RISE];
    assign clr_fall = bus_wr_i && (bus_addr_i == ADDR_STAT) && bus_wdata_i[B_FALL];

    // Sticky flags: a new edge outranks a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_flag_q <= 1'b0;
            fall_flag_q <= 1'b0;
        end else begin
            rise_flag_q <= edge_i.rise | (rise_flag_q & ~clr_rise);
            fall_flag_q <= edge_i.fall | (fall_flag_q & ~clr_fall);
        end
    end

    // Interrupt enables
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_ie_q <= 1'b0;
            fall_ie_q <= 1'b0;
        end else if (wr_ie) begin
            rise_ie_q <= bus_wdata_i[IE_RISE];
            fall_ie_q <= bus_wdata_i[IE_FALL];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            ADDR_IE: begin
                bus_rdata_o[IE_RISE] = rise_ie_q;
                bus_rdata_o[IE_FALL] = fall_ie_q;
            end
            ADDR_STAT: begin
                bus_rdata_o[B_LVL]  = lvl_i;
                bus_rdata_o[B_RISE] = rise_flag_q;
                bus_rdata_o[B_FALL] = fall_flag_q;
            end
            default: bus_rdata_o = '0;
        endcase
    end

    assign irq_o = ((rise_flag_q & rise_ie_q) | (fall_flag_q & fall_ie_q))
                   & src_ie_i & gie_i;

    assert_rise_sets_R4: assert property (@(posedge clk) disable iff (rst)
        edge_i.rise |=> rise_flag_q);

    assert_fall_sets_R5: assert property (@(posedge clk) disable iff (rst)
        edge_i.fall |=> fall_flag_q);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (rise_flag_q && !clr_rise) |=> rise_flag_q);

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (edge_i.fall && clr_fall) |=> fall_flag_q);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (src_ie_i && gie_i && (rise_flag_q || fall_flag_q)));
endmodule

// File: rtl/cmp_irq_cond.sv
module cmp_irq_cond
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_raw_i,
    input  logic             cmp_en_i,
    input  logic             src_ie_i,
    input  logic             gie_i,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    output logic             cmp_async_o,
    output logic             cmp_sync_o,
    output logic             irq_o
);
    logic       gated;
    edge_pair_t edges;

    // R1/R3: disabled comparator reads zero on the unclocked path
    assign gated       = cmp_raw_i & cmp_en_i;
    assign cmp_async_o = gated;

    cmp_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (gated),
        .q_o (cmp_sync_o)
    );

    cmp_edge_fsm u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (cmp_sync_o),
        .edge_o (edges)
    );

    cmp_flag_bank u_flags (
        .clk         (clk),
        .rst         (rst),
        .edge_i      (edges),
        .lvl_i       (cmp_sync_o),
        .src_ie_i    (src_ie_i),
        .gie_i       (gie_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    // R3: disabled for a full synchronizer span gives a low synchronized output
    assert_off_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmp_en_i && $past(!cmp_en_i)) |=> !cmp_sync_o);
endmodule

// File: tb/test_cmp_irq_cond.sv
`timescale 1ns/1ps
module test_cmp_irq_cond;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw = 1'b0, en = 1'b0, src = 1'b0, gie = 1'b0;
    logic       wr = 1'b0, addr = 1'b0;
    logic [2:0] wdata = '0;
    logic [2:0] rdata;
    logic       async_o, sync_o, irq;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state
    logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_rf = 0, m_ff = 0, m_rie = 0, m_fie = 0;

    always #2.5 clk = ~clk;

    cmp_irq_cond i_cmp_irq_cond (
        .clk(clk), .rst(rst), .cmp_raw_i(raw), .cmp_en_i(en),
        .src_ie_i(src), .gie_i(gie), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cmp_async_o(async_o),
        .cmp_sync_o(sync_o), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
            m_rf <= 0; m_ff <= 0; m_rie <= 0; m_fie <= 0;
        end else begin
            m_s1   <= raw & en;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_rf <= (m_s2 & ~m_prev) | (m_rf & ~(wr & addr & wdata[1]));
            m_ff <= (~m_s2 & m_prev) | (m_ff & ~(wr & addr & wdata[2]));
            if (wr && !addr) begin
                m_rie <= wdata[0];
                m_fie <= wdata[1];
            end
        end
    end

    function automatic logic [2:0] exp_rdata(input logic a);
        return a ? {m_ff, m_rf, m_s2} : {1'b0, m_fie, m_rie};
    endfunction

    function automatic logic exp_irq();
        return ((m_rf & m_rie) | (m_ff & m_fie)) & src & gie;
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R1 async path", {2'b0, async_o}, {2'b0, raw & en});
        if (!en) chk("R3 disabled async low", {2'b0, async_o}, 3'b0);
        chk("R2 sync delay", {2'b0, sync_o}, {2'b0, m_s2});
        chk(addr ? "R10 status read (R4 R5 R6 R7)" : "R9 enable read", rdata, exp_rdata(addr));
        chk("R8 irq level", {2'b0, irq}, {2'b0, exp_irq()});
    endtask

    // One cycle: drive at negedge, check after the next negedge
    task automatic cyc(input logic r, input logic e, input logic w, input logic a,
                       input logic [2:0] d, input logic s, input logic g);
        @(negedge clk);
        raw = r; en = e; wr = w; addr = a; wdata = d; src = s; gie = g;
        #1 check_all();
    endtask

    initial begin
        #(5 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        raw = 1; en = 1; addr = 1;
        #1;
        // R11: reset state
        chk("R11 reset status", rdata, 3'b000);
        chk("R11 reset sync", {2'b0, sync_o}, 3'b0);
        @(negedge clk); rst = 0;
        // Directed: rise with no enables set (R4), flags readable
        cyc(1,1,0,1,3'b0,1,1);
        cyc(1,1,0,1,3'b0,1,1);
        cyc(1,1,0,1,3'b0,1,1);
        cyc(1,1,0,1,3'b0,1,1);
        chk("R4 rise flag without enables", {2'b0, rdata[1]}, 3'b001);
        // R3: disable while high gives a fall flag
        cyc(1,0,0,1,3'b0,1,1);
        cyc(1,0,0,1,3'b0,1,1);
        cyc(1,0,0,1,3'b0,1,1);
        cyc(1,0,0,1,3'b0,1,1);
        chk("R3 disable flags fall", rdata, 3'b110);
        // R6: writing zeros leaves flags
        cyc(0,0,1,1,3'b000,1,1);
        cyc(0,0,0,1,3'b000,1,1);
        chk("R6 zero write keeps flags", rdata, 3'b110);
        // R9 + R8: enable fall irq
        cyc(0,0,1,0,3'b010,1,1);
        cyc(0,0,0,0,3'b000,1,1);
        chk("R8 irq on fall flag", {2'b0, irq}, 3'b001);
        cyc(0,0,0,0,3'b000,1,0);
        chk("R8 gie masks irq", {2'b0, irq}, 3'b000);
        // R6: clear both flags
        cyc(0,0,1,1,3'b110,1,1);
        cyc(0,0,0,1,3'b000,1,1);
        chk("R6 write one clears", rdata, 3'b000);
        // R7: clear in the same cycle as a rise edge
        cyc(1,1,0,1,3'b0,1,1);  // s1 after this edge
        cyc(1,1,0,1,3'b0,1,1);  // s2 high, edge pulse active now
        cyc(1,1,1,1,3'b010,1,1); // clear lands with the rise pulse
        cyc(1,1,0,1,3'b000,1,1);
        chk("R7 edge beats clear", {2'b0, rdata[1]}, 3'b001);

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            logic r = 1'($urandom_range(0, 1));
            logic e = ($urandom_range(0, 9) != 0);
            int   hold = $urandom_range(1, 4);
            for (int k = 0; k < hold; k++) begin
                logic       w = ($urandom_range(0, 5) == 0);
                logic       a = 1'($urandom_range(0, 1));
                logic [2:0] d = 3'($urandom_range(0, 7));
                cyc(r, e, w, a, d, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0));
            end
        end

        // R11: reset mid-run clears everything
        @(negedge clk); rst = 1; wr = 0;
        @(negedge clk); rst = 0; raw = 0; addr = 0;
        #1;
        chk("R11 reset clears enables", rdata, 3'b000);
        addr = 1; #1;
        chk("R11 reset clears flags", rdata, 3'b000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule